// File: doc/BRIEF.md
# Column-Controlled Buffered Permutation Network

This block moves fixed-size packets across a multistage network of N = 2^ADDR_W ports. It has one stage per address bit. Every switching element in a stage obeys a single shared control bit. With the bit clear, the stage passes each port straight through. With the bit set, the stage swaps each port with its partner whose index differs in that stage's address bit. The first stage works on the most significant address bit, and each later stage works on the next lower bit.

The control bits are not derived from traffic. They come from a two-state slot scheduler that alternates every clock cycle, and odd-numbered stages run in the opposite phase to even-numbered stages. Each stage input has a FIFO queue. A packet at the head of a queue leaves only in a slot whose stage state matches what the packet needs. At all other times it waits. After the last stage, every packet sits on the port named by its destination.

The scheduler has two states:
- PH_IDENT: even stages pass straight, odd stages swap.
- PH_CUBE: even stages swap, odd stages pass straight.

It has two transitions, both unconditional and taken on every clock after reset:
- toggle_to_cube: PH_IDENT to PH_CUBE.
- toggle_to_ident: PH_CUBE to PH_IDENT.

Top module: `cpn_fabric`

## Requirements
- R1: While reset is held and right after it is released, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: Let t be the number of clock edges since reset was released. Stage s (s = 0 is the first stage) is in swap state exactly when t + s is odd. Reset leaves the scheduler in PH_IDENT.
- R3: Stage s handles address bit ADDR_W-1-s. A head packet at port p needs the swap state when bit ADDR_W-1-s of p differs from the same bit of its destination, and needs the straight state otherwise.
- R4: Every accepted packet appears exactly once on `out_valid`/`out_data` of its destination port, with its payload unchanged.
- R5: On an otherwise empty network, a packet accepted at edge T spends one edge per stage. It spends one more edge at a stage only when that stage's state mismatches its need on arrival. It shows up on the output one edge after leaving the last stage.
- R6: `in_ready[p]` is 0 exactly while the first-stage queue of port p holds DEPTH packets. An offer made while `in_ready[p]` is 0 is ignored and never delivered.
- R7: A head packet whose target queue in the next stage is full stays where it is. No packet is dropped or duplicated under congestion.
- R8: Packets from one input to one output leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one slot per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N | Per-port offer of a packet |
| in_dest | input | N*ADDR_W | Per-port destination index, port p at bits [p*ADDR_W +: ADDR_W] |
| in_data | input | N*DATA_W | Per-port payload, port p at bits [p*DATA_W +: DATA_W] |
| in_ready | output | N | Per-port space in the first-stage queue |
| out_valid | output | N | Per-port delivered packet strobe |
| out_data | output | N*DATA_W | Per-port delivered payload |

## Verification
The hardest situation to create from the ports is a full queue inside the network that blocks a head packet one stage upstream. The only exit path has no backpressure, and a single source fills just its own first-stage queue. The bench creates this case by driving ports 0 and 4 toward the same destination on every cycle. Both streams then merge into one second-stage queue, and every packet in that queue needs the swap state, which is present only on alternate slots. The bench then checks delivery count and per-pair order. A separate set of single-packet runs, each started on a chosen slot parity, pins down the exact arrival edge the schedule predicts.

// File: rtl/cpn_pkg.sv
package cpn_pkg;
    // Slot scheduler phase; value equals the swap state of even stages.
    typedef enum logic {
        PH_IDENT = 1'b0,
        PH_CUBE  = 1'b1
    } phase_e;
endpackage

// File: rtl/cpn_fifo.sv
module cpn_fifo #(
    parameter int W     = 19,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic         head_valid,
    output logic [W-1:0] head_data,
    output logic         full
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_q, wr_q;
    logic [CNT_W-1:0] cnt_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= nxt(wr_q);
            if (pop)  rd_q <= nxt(rd_q);
            cnt_q <= cnt_q + CNT_W'(push) - CNT_W'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= push_data;
    end

    assign head_valid = (cnt_q != '0);
    assign head_data  = mem[rd_q];
    assign full       = (cnt_q == CNT_W'(DEPTH));

    // R7: upstream must hold its head instead of writing into a full queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    // R5: a stage only removes a packet that is present
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_valid);
endmodule

// File: rtl/cpn_slot_sched.sv
module cpn_slot_sched
    import cpn_pkg::*;
#(
    parameter int STAGES = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [STAGES-1:0] cube_sel
);
    phase_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDENT: state_d = PH_CUBE;   // toggle_to_cube
            PH_CUBE:  state_d = PH_IDENT;  // toggle_to_ident
            default:  state_d = PH_IDENT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_IDENT;
        else        state_q <= state_d;
    end

    always_comb begin
        for (int s = 0; s < STAGES; s++) begin
            cube_sel[s] = (state_q == PH_CUBE) ^ s[0];
        end
    end

    // R2: the phase flips on every slot
    assert_ident_then_cube_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_IDENT) |=> (state_q == PH_CUBE));
    assert_cube_then_ident_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_CUBE) |=> (state_q == PH_IDENT));
endmodule

// File: rtl/cpn_stage.sv
module cpn_stage #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2,
    parameter int BIT    = 2
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          cube_sel,
    input  logic [(1<<ADDR_W)-1:0]                        in_push,
    input  logic [(1<<ADDR_W)-1:0][ADDR_W+DATA_W-1:0]     in_pkt,
    output logic [(1<<ADDR_W)-1:0]                        in_full,
    output logic [(1<<ADDR_W)-1:0]                        fwd_valid,
    output logic [(1<<ADDR_W)-1:0][ADDR_W+DATA_W-1:0]     fwd_pkt,
    input  logic [(1<<ADDR_W)-1:0]                        dn_full
);
    localparam int N     = 1 << ADDR_W;
    localparam int PKT_W = ADDR_W + DATA_W;
    localparam int DBIT  = DATA_W + BIT;   // destination bit this stage settles

    logic [N-1:0]            head_v;
    logic [N-1:0][PKT_W-1:0] head_pkt;
    logic [N-1:0]            need_swap;
    logic [N-1:0]            tgt_full;
    logic [N-1:0]            pop;

    for (genvar p = 0; p < N; p++) begin : g_port
        localparam int   PX = p ^ (1 << BIT);
        localparam logic PB = ((p >> BIT) & 1) != 0;

        cpn_fifo #(.W(PKT_W), .DEPTH(DEPTH)) q_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (in_push[p]),
            .push_data (in_pkt[p]),
            .pop       (pop[p]),
            .head_valid(head_v[p]),
            .head_data (head_pkt[p]),
            .full      (in_full[p])
        );

        // R3: swap needed when this port's bit differs from the destination bit
        assign need_swap[p] = PB ^ head_pkt[p][DBIT];
        assign tgt_full[p]  = cube_sel ? dn_full[PX] : dn_full[p];
        // R7: hold the head while the target queue is full
        assign pop[p]       = head_v[p] & (need_swap[p] == cube_sel) & ~tgt_full[p];
        assign fwd_valid[p] = cube_sel ? pop[PX] : pop[p];
        assign fwd_pkt[p]   = cube_sel ? head_pkt[PX] : head_pkt[p];

        // R3: whatever leaves on port p now agrees with the destination in this bit
        assert_bit_settled_R3: assert property (@(posedge clk) disable iff (!rst_n)
            fwd_valid[p] |-> (fwd_pkt[p][DBIT] == PB));
    end
endmodule

// File: rtl/cpn_fabric.sv
module cpn_fabric #(
    parameter int ADDR_W = 3,
    parameter int DATA_W = 16,
    parameter int DEPTH  = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [(1<<ADDR_W)-1:0]         in_valid,
    input  logic [(1<<ADDR_W)*ADDR_W-1:0]  in_dest,
    input  logic [(1<<ADDR_W)*DATA_W-1:0]  in_data,
    output logic [(1<<ADDR_W)-1:0]         in_ready,
    output logic [(1<<ADDR_W)-1:0]         out_valid,
    output logic [(1<<ADDR_W)*DATA_W-1:0]  out_data
);
    localparam int N      = 1 << ADDR_W;
    localparam int PKT_W  = ADDR_W + DATA_W;
    localparam int STAGES = ADDR_W;

    logic [STAGES-1:0]                  cube_sel;
    logic [STAGES:0][N-1:0]             link_valid;
    logic [STAGES:0][N-1:0]             link_full;
    logic [STAGES:0][N-1:0][PKT_W-1:0]  link_pkt;

    cpn_slot_sched #(.STAGES(STAGES)) sched_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cube_sel(cube_sel)
    );

    // Injection link (R6)
    assign in_ready      = ~link_full[0];
    assign link_valid[0] = in_valid & in_ready;
    for (genvar p = 0; p < N; p++) begin : g_inj
        assign link_pkt[0][p] = {in_dest[p*ADDR_W +: ADDR_W], in_data[p*DATA_W +: DATA_W]};
    end
    assign link_full[STAGES] = '0;

    // Stage s settles address bit ADDR_W-1-s
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        cpn_stage #(
            .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .BIT(ADDR_W - 1 - s)
        ) stage_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .cube_sel (cube_sel[s]),
            .in_push  (link_valid[s]),
            .in_pkt   (link_pkt[s]),
            .in_full  (link_full[s]),
            .fwd_valid(link_valid[s+1]),
            .fwd_pkt  (link_pkt[s+1]),
            .dn_full  (link_full[s+1])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= link_valid[STAGES];
            for (int q = 0; q < N; q++) begin
                out_data[q*DATA_W +: DATA_W] <= link_pkt[STAGES][q][DATA_W-1:0];
            end
        end
    end

    for (genvar q = 0; q < N; q++) begin : g_chk
        // R4: the last stage only emits on the destination port
        assert_final_port_R4: assert property (@(posedge clk) disable iff (!rst_n)
            link_valid[STAGES][q] |-> (link_pkt[STAGES][q][PKT_W-1 -: ADDR_W] == ADDR_W'(q)));
    end
endmodule

// File: tb/cpn_fabric_tb.sv
module cpn_fabric_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 3;
    localparam int NP = 1 << AW;
    localparam int DW = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic [NP-1:0]      in_valid = '0;
    logic [NP*AW-1:0]   in_dest = '0;
    logic [NP*DW-1:0]   in_data = '0;
    logic [NP-1:0]      in_ready;
    logic [NP-1:0]      out_valid;
    logic [NP*DW-1:0]   out_data;

    int n_checks = 0, n_err = 0;
    int tick = 0;
    int sent_total = 0, recv_total = 0, refused = 0;
    int send_seq [NP][NP];
    int recv_seq [NP][NP];
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpn_fabric #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data)
    );

    always @(posedge clk) begin
        if (!rst_n) tick <= 0;
        else        tick <= tick + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: payload = {dst[3:0], src[3:0], seq[7:0]}
    always @(negedge clk) begin
        if (rst_n) begin
            for (int q = 0; q < NP; q++) begin
                if (out_valid[q]) begin
                    logic [DW-1:0] pl;
                    int d, s;
                    pl = out_data[q*DW +: DW];
                    d = int'(pl[15:12]);
                    s = int'(pl[11:8]);
                    chk(d == q, "R4 delivery port", q, d);
                    if (d < NP && s < NP) begin
                        chk(int'(pl[7:0]) == (recv_seq[s][d] & 255), "R8 per-pair order",
                            int'(pl[7:0]), recv_seq[s][d] & 255);
                        recv_seq[s][d]++;
                    end
                    recv_total++;
                end
            end
        end
    end

    // One slot of stimulus; an offer on a non-ready port is driven but not counted (R6)
    task automatic step(input logic [NP-1:0] want, input logic [NP*AW-1:0] dsts);
        @(negedge clk);
        for (int p = 0; p < NP; p++) begin
            int d;
            d = int'(dsts[p*AW +: AW]);
            in_valid[p] = want[p];
            in_dest[p*AW +: AW] = dsts[p*AW +: AW];
            in_data[p*DW +: DW] = {4'(d), 4'(p), 8'(send_seq[p][d])};
            if (want[p] && in_ready[p]) begin
                send_seq[p][d]++;
                sent_total++;
            end else if (want[p]) begin
                refused++;
            end
        end
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step('0, '0);
    endtask

    task automatic check_conservation(input string tag);
        int bad;
        bad = 0;
        for (int s = 0; s < NP; s++)
            for (int d = 0; d < NP; d++)
                if (send_seq[s][d] != recv_seq[s][d]) bad++;
        chk(recv_total == sent_total, tag, recv_total, sent_total);
        chk(bad == 0, tag, bad, 0);
    endtask

    function automatic int model_arrival(input int t0, input int src, input int dst);
        int t, port;
        t = t0 + 1;
        port = src;
        for (int s = 0; s < AW; s++) begin
            int b, need, cube;
            b = AW - 1 - s;
            need = ((port >> b) & 1) ^ ((dst >> b) & 1);
            cube = (t + s) & 1;
            if (need != cube) t++;
            t++;
            if (need != 0) port = port ^ (1 << b);
        end
        return t;
    endfunction

    task automatic t_reset();
        chk(in_ready == '1, "R1 in_ready after reset", int'(in_ready), 255);
        chk(out_valid == '0, "R1 out_valid after reset", int'(out_valid), 0);
    endtask

    // R2 R3 R5: exact arrival edge of a lone packet
    task automatic t_latency(input int src, input int dst, input int skew);
        logic [NP*AW-1:0] ds;
        int t0, exp, found;
        idle(skew);
        ds = '0;
        ds[src*AW +: AW] = AW'(dst);
        step(NP'(1 << src), ds);
        t0 = tick;
        exp = model_arrival(t0, src, dst);
        found = -1;
        for (int k = 0; k < 24; k++) begin
            step('0, '0);
            if (found < 0 && out_valid[dst]) found = tick;
        end
        chk(found == exp, "R2/R3/R5 arrival edge", found, exp);
    endtask

    // R6: one port streaming; its first queue fills and offers get refused
    task automatic t_burst_single();
        logic [NP*AW-1:0] ds;
        int r0;
        r0 = refused;
        ds = '0;
        ds[0 +: AW] = AW'(4);
        for (int k = 0; k < 14; k++) step(NP'(1), ds);
        idle(30);
        chk(refused > r0, "R6 in_ready dropped on full queue", refused - r0, 1);
        check_conservation("R6 refused offers never delivered");
    endtask

    // R7: two streams merge into one second-stage queue that drains on half the slots
    task automatic t_hotspot();
        logic [NP*AW-1:0] ds;
        ds = '0;
        ds[0*AW +: AW] = AW'(2);
        ds[4*AW +: AW] = AW'(2);
        for (int k = 0; k < 24; k++) step(NP'(8'h11), ds);
        idle(60);
        check_conservation("R7 hold under congestion");
    endtask

    // R4 R7 R8: random offers and destinations on every port
    task automatic t_random();
        for (int k = 0; k < 400; k++) step(NP'($urandom), (NP*AW)'($urandom));
        idle(100);
        check_conservation("R4/R7/R8 random traffic");
    endtask

    initial begin
        for (int s = 0; s < NP; s++)
            for (int d = 0; d < NP; d++) begin
                send_seq[s][d] = 0;
                recv_seq[s][d] = 0;
            end
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R1 out_valid in reset", int'(out_valid), 0);
        rst_n = 1'b1;
        t_reset();
        t_latency(0, 0, 0);
        t_latency(0, 0, 1);
        t_latency(0, 7, 0);
        t_latency(0, 7, 1);
        t_latency(6, 1, 0);
        t_latency(5, 2, 1);
        t_latency(3, 3, 0);
        t_burst_single();
        t_hotspot();
        t_random();
        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", tick, 0);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end
endmodule